// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block runs one successive-approximation conversion at a time for a 10-bit converter. A free-running power-of-two prescaler divides the system clock into a converter tick. Once a start request has been accepted, the sequencer produces a single sample-and-hold strobe. It then drives a trial code to an external DAC and settles one result bit per converter clock, reading a one-bit comparator input. At the end it publishes the result together with a one-cycle done strobe.

The first conversion after the block is enabled is stretched so that the analog side has time to settle. Every later conversion is short. A busy flag is high from the moment a request is accepted until the result is written. An input-select field, which carries the channel and reference choice, is passed to the analog side only while the block is enabled and idle. A change requested in the middle of a conversion therefore takes effect only after that conversion has finished.

Top module: `sar_seq`

## Requirements
- R1: The converter tick period is D system clocks, with D = 2 for `psel_i` = 0 or 1 and D = 2^`psel_i` for values 2 to 7.
- R2: While `en_i` is low, the prescaler stays cleared, `start_i` is ignored and `busy_o` stays low.
- R3: An accepted start begins the conversion on the next converter tick. `done_o` rises between 13·D+1 and 14·D system clock edges after the edge that sampled `start_i`, and for a first conversion between 25·D+1 and 26·D.
- R4: A normal conversion ends 13 converter clocks after its start. Its one-cycle `sample_o` pulse falls 1.5 converter clocks after the start, so done follows sample by 11.5·D system clocks.
- R5: The first conversion after enable lasts 25 converter clocks and samples at 14.5, so done follows sample by 10.5·D system clocks.
- R6: `busy_o` is high from the cycle after an accepted start until the cycle in which `done_o` pulses. It is low in that cycle, and `done_o` lasts exactly one cycle.
- R7: Result bits are decided from MSB to LSB, one per converter clock. A trial bit is kept when `cmp_i` is 1 (input at or above the DAC level). With an ideal comparator the result equals the input code.
- R8: `dac_o` is 0 while idle and equals 0x200 (MSB trial, no bits kept) at the sample pulse.
- R9: A start request while busy is ignored. Exactly one done pulse follows each accepted start.
- R10: `sel_o` follows `sel_i` only in cycles where the block is enabled and not busy. It holds during a conversion and while disabled.
- R11: Dropping `en_i` during a conversion aborts it without a done pulse, and the next conversion is again a first conversion (R5 timing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Block enable; low holds the prescaler cleared and aborts |
| start_i | input | 1 | Conversion request |
| psel_i | input | 3 | Prescaler select |
| sel_i | input | 3 | Requested channel/reference selection |
| cmp_i | input | 1 | Comparator: 1 when input is at or above the DAC level |
| busy_o | output | 1 | Conversion pending or running |
| sample_o | output | 1 | One-cycle sample-and-hold strobe |
| dac_o | output | 10 | Trial code to the DAC |
| result_o | output | 10 | Last completed result |
| done_o | output | 1 | One-cycle completion strobe |
| sel_o | output | 3 | Selection applied to the analog side |

## Verification
The bench measures the distance from the sample strobe to done. That distance exposes a first-conversion stretch placed in the wrong conversion, a sample point off by a half tick, and a prescaler select that decodes 0 and 1 differently. Input codes of 0 and full scale catch a compare with the wrong polarity or the wrong order. A second start pulse in mid-conversion and an enable drop in mid-conversion catch a sequencer that restarts, sends a spurious done, or forgets to treat the next conversion as a first one. The selection latch is probed while busy and while disabled, so a latch that leaks changes through shows up directly.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W   = 10;
  localparam int PS_W    = 7;
  localparam int PSEL_W  = 3;
  localparam int SEL_W   = 3;
  localparam int N_NORM  = 13;
  localparam int N_FIRST = 25;
  localparam int S_NORM  = 1;
  localparam int S_FIRST = 14;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int PS_W   = sar_pkg::PS_W,
  parameter int PSEL_W = sar_pkg::PSEL_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] psel_i,
  output logic              tick_o,
  output logic              half_o
);
  logic [PS_W-1:0]   cnt_q;
  logic [PS_W-1:0]   mask;
  logic [PSEL_W-1:0] dlog;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + PS_W'(1);
  end

  always_comb begin
    dlog   = (psel_i == '0) ? PSEL_W'(1) : psel_i;
    mask   = (PS_W'(1) << dlog) - PS_W'(1);
    tick_o = en_i && ((cnt_q & mask) == mask);
    half_o = en_i && ((cnt_q & mask) == (mask >> 1));
  end

  AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
endmodule

// File: rtl/sar_ctrl.sv
module sar_ctrl #(
  parameter int RES_W   = sar_pkg::RES_W,
  parameter int N_NORM  = sar_pkg::N_NORM,
  parameter int N_FIRST = sar_pkg::N_FIRST,
  parameter int S_NORM  = sar_pkg::S_NORM,
  parameter int S_FIRST = sar_pkg::S_FIRST
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic             half_i,
  input  logic             cmp_i,
  output logic             busy_o,
  output logic             sample_o,
  output logic [RES_W-1:0] dac_o,
  output logic [RES_W-1:0] result_o,
  output logic             done_o
);
  localparam int CC_W = $clog2(N_FIRST + 1);
  localparam logic [RES_W-1:0] MSB_TRIAL = RES_W'(1) << (RES_W - 1);

  logic             pend_q, run_q, first_q, done_q, samp_q;
  logic [CC_W-1:0]  cc_q;
  logic [RES_W-1:0] code_q, trial_q, res_q;
  logic [CC_W-1:0]  n_last, s_idx, dec_lo;

  always_comb begin
    n_last = first_q ? CC_W'(N_FIRST - 1) : CC_W'(N_NORM - 1);
    s_idx  = first_q ? CC_W'(S_FIRST) : CC_W'(S_NORM);
    dec_lo = n_last - CC_W'(RES_W - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0; run_q <= 1'b0; first_q <= 1'b1;
      done_q <= 1'b0; samp_q <= 1'b0; cc_q <= '0;
      code_q <= '0; trial_q <= '0; res_q <= '0;
    end else begin
      done_q <= 1'b0;
      samp_q <= 1'b0;
      if (!en_i) begin
        pend_q  <= 1'b0;
        run_q   <= 1'b0;
        first_q <= 1'b1;
        code_q  <= '0;
        trial_q <= '0;
      end else begin
        if (start_i && !pend_q && !run_q) pend_q <= 1'b1;
        if (pend_q && tick_i) begin
          pend_q  <= 1'b0;
          run_q   <= 1'b1;
          cc_q    <= '0;
          code_q  <= '0;
          trial_q <= MSB_TRIAL;
        end
        if (run_q) begin
          if (cc_q == s_idx && half_i) samp_q <= 1'b1;
          if (tick_i) begin
            cc_q <= cc_q + CC_W'(1);
            if (cc_q >= dec_lo) begin
              if (cmp_i) code_q <= code_q | trial_q;
              trial_q <= trial_q >> 1;
            end
            if (cc_q == n_last) begin
              run_q   <= 1'b0;
              done_q  <= 1'b1;
              first_q <= 1'b0;
              res_q   <= cmp_i ? (code_q | trial_q) : code_q;
              code_q  <= '0;
              trial_q <= '0;
            end
          end
        end
      end
    end
  end

  assign busy_o   = pend_q | run_q;
  assign sample_o = samp_q;
  assign dac_o    = code_q | trial_q;
  assign result_o = res_q;
  assign done_o   = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R6
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o); // R6
  AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!busy_o && !done_o)); // R11
  AST_TRIAL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(trial_q)); // R7
  AST_SAMPLE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |-> busy_o); // R4
endmodule

// File: rtl/sar_sel_hold.sv
module sar_sel_hold #(
  parameter int SEL_W = sar_pkg::SEL_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             busy_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [SEL_W-1:0] sel_o
);
  logic [SEL_W-1:0] sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                sel_q <= '0;
    else if (en_i && !busy_i)   sel_q <= sel_i;
  end

  assign sel_o = sel_q;

  AST_SEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(busy_i) |-> $stable(sel_o)); // R10
endmodule

// File: rtl/sar_seq.sv
module sar_seq
  import sar_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              start_i,
  input  logic [PSEL_W-1:0] psel_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic              cmp_i,
  output logic              busy_o,
  output logic              sample_o,
  output logic [RES_W-1:0]  dac_o,
  output logic [RES_W-1:0]  result_o,
  output logic              done_o,
  output logic [SEL_W-1:0]  sel_o
);
  logic tick, half;

  sar_prescaler #(.PS_W(PS_W), .PSEL_W(PSEL_W)) u_ps (
    .clk_i, .rst_ni, .en_i, .psel_i, .tick_o(tick), .half_o(half)
  );

  sar_ctrl #(
    .RES_W(RES_W), .N_NORM(N_NORM), .N_FIRST(N_FIRST),
    .S_NORM(S_NORM), .S_FIRST(S_FIRST)
  ) u_ctrl (
    .clk_i, .rst_ni, .en_i, .start_i, .tick_i(tick), .half_i(half), .cmp_i,
    .busy_o, .sample_o, .dac_o, .result_o, .done_o
  );

  sar_sel_hold #(.SEL_W(SEL_W)) u_sel (
    .clk_i, .rst_ni, .en_i, .busy_i(busy_o), .sel_i, .sel_o
  );
endmodule

// File: tb/tb_sar_seq.sv
module tb_sar_seq;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0, start_i = 1'b0;
  logic [2:0] psel_i = '0, sel_i = '0;
  logic       cmp_i;
  logic       busy_o, sample_o, done_o;
  logic [9:0] dac_o, result_o, vin = '0;
  logic [2:0] sel_o;

  int checks = 0, failures = 0, cyc = 0, s_cyc = 0;
  int exp_res[$];
  int exp_gap[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc++;
  assign cmp_i = (vin >= dac_o);

  sar_seq dut (.clk_i(clk), .rst_ni, .en_i, .start_i, .psel_i, .sel_i, .cmp_i,
               .busy_o, .sample_o, .dac_o, .result_o, .done_o, .sel_o);

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // monitor: sample position, dac at sample, result and sample-to-done gap
  always @(negedge clk) begin
    if (rst_ni && sample_o) begin
      s_cyc = cyc;
      chk(dac_o == 10'h200, "R8 dac at sample", dac_o, 10'h200);
    end
    if (rst_ni && done_o) begin
      if (exp_res.size() == 0) chk(1'b0, "R9/R11 unexpected done", 1, 0);
      else begin
        int er, eg;
        er = exp_res.pop_front();
        eg = exp_gap.pop_front();
        chk(result_o == 10'(er), "R7 result", result_o, er);
        chk(cyc - s_cyc == eg, "R4/R5 sample-to-done", cyc - s_cyc, eg);
      end
    end
  end

  function automatic int div_of(input int p);
    return (p <= 1) ? 2 : (1 << p);
  endfunction

  task automatic run_conv(input int v, input bit first, input int p);
    int d, n, nconv;
    d = div_of(p);
    nconv = first ? 25 : 13;
    psel_i = 3'(p);
    vin = 10'(v);
    exp_res.push_back(v);
    exp_gap.push_back(first ? 21*d/2 : 23*d/2);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(busy_o == 1'b1, "R6 busy after start", busy_o, 1);
    n = 0;
    while (!done_o) begin @(negedge clk); n++; end
    chk(n >= nconv*d+1 && n <= (nconv+1)*d, "R1/R3 start-to-done", n, nconv*d+1);
    chk(busy_o == 1'b0, "R6 busy low at done", busy_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy_o == 0 && done_o == 0, "R6 reset idle", busy_o, 0);
    chk(dac_o == 0 && result_o == 0, "R8 reset dac/result", dac_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    en_i = 1'b1;
    run_conv(300, 1, 0);   // R5 first conversion
    run_conv(0, 0, 0);     // R7 zero
    run_conv(1023, 0, 0);  // R7 full scale
    run_conv(512, 0, 1);   // R1 psel 1 also /2
    run_conv(341, 0, 3);   // R1 /8
    run_conv(682, 0, 7);   // R1 /128
    chk(dac_o == 0, "R8 dac idle", dac_o, 0);

    // R9: extra start while busy
    psel_i = 3'd2; vin = 10'd777;
    exp_res.push_back(777); exp_gap.push_back(23*4/2);
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (20) @(negedge clk);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    while (!done_o) @(negedge clk);
    repeat (150) @(negedge clk);
    chk(busy_o == 0, "R9 no restart", busy_o, 0);
    chk(exp_res.size() == 0, "R9 single done", exp_res.size(), 0);

    // R10: selection latch
    sel_i = 3'd5; repeat (2) @(negedge clk);
    chk(sel_o == 3'd5, "R10 idle follows", sel_o, 5);
    vin = 10'd100; psel_i = 3'd0;
    exp_res.push_back(100); exp_gap.push_back(23);
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    sel_i = 3'd2; repeat (5) @(negedge clk);
    chk(sel_o == 3'd5, "R10 held while busy", sel_o, 5);
    while (!done_o) @(negedge clk);
    @(negedge clk);
    chk(sel_o == 3'd2, "R10 applied after done", sel_o, 2);
    en_i = 1'b0; sel_i = 3'd7; repeat (3) @(negedge clk);
    chk(sel_o == 3'd2, "R10 held while disabled", sel_o, 2);

    // R2: start ignored while disabled
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (60) @(negedge clk);
    chk(busy_o == 0, "R2 start ignored when off", busy_o, 0);
    en_i = 1'b1; @(negedge clk);
    chk(sel_o == 3'd7, "R10 applied on enable", sel_o, 7);
    run_conv(400, 1, 0);   // R5 first again after re-enable

    // R11: abort mid conversion
    vin = 10'd55;
    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
    repeat (12) @(negedge clk);
    en_i = 1'b0; @(negedge clk);
    chk(busy_o == 0, "R11 abort clears busy", busy_o, 0);
    repeat (80) @(negedge clk);
    en_i = 1'b1;
    run_conv(901, 1, 0);   // R11 next is first conversion
    repeat (5) @(negedge clk);
    chk(exp_res.size() == 0, "R11 no pending results", exp_res.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule